// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer sits between a stream of 32-bit command words and a downstream drawing or transfer engine. Each packet starts with a header word whose top byte is the opcode. The framer looks the opcode up in a sparse table of parameter counts, or, for polyline opcodes, searches for a terminator word. It forwards the packet word by word and marks the first and last words. It also tags each word with a class: draw, copy, image write or image read.

Settings opcodes never reach the downstream side. Their whole word is captured into an eight-entry register bank, which is exposed as a flat output bus. Unlisted opcodes are swallowed as single-word no-ops.

The datapath is a pass-through with combinational valid and ready. A packet whose words have not all arrived therefore stays open, and its last flag is withheld until the closing word shows up. Words inside an open packet are never decoded as opcodes.

Top module: `gpu_packet_framer`

## Requirements
- R1: After reset no packet is open, so the next accepted word is a header. Settings entry i holds the value {8'hE0+i, 24'h0}.
- R2: The opcode is bits 31:24 of the header. A fixed packet is one header word plus its parameter count. `out_first` is high only on the header and `out_last` only on the final word. `out_kind` keeps one value for the whole packet.
- R3: Opcodes 0x20-0x3F take, in groups of four, 3,6,4,8,5,8,7,11 parameter words.
- R4: Opcode 0x02 takes 2 parameter words. The non-polyline opcodes 0x40-0x7F take counts by group of four: 0x40-0x47 2, 0x50-0x57 3, 0x60 2, 0x64 3, 0x68 1, 0x6C 0, 0x70 1, 0x74 2, 0x78 1, 0x7C 2. All of these are kind 0 (draw).
- R5: Opcodes 0x48-0x4F are open-ended. Starting at word index 3 (the header is index 0), every word is tested, and the first one with (word & 0xF000F000) == 0x50005000 closes the packet as its last word.
- R6: Opcodes 0x58-0x5F are open-ended. Only even word indices from 4 upward are tested for the terminator pattern of R5. Terminator-shaped words at other indices do not close the packet.
- R7: Opcodes 0x80-0x9F are kind 1 (copy) with 3 parameter words. Opcodes 0xA0-0xBF are kind 2 (image write) and 0xC0-0xDF are kind 3 (image read), each with 2 parameter words.
- R8: A header with opcode 0xE0-0xE7 is consumed without output. Its full word is written to settings entry opcode[2:0], and the other entries are left unchanged.
- R9: Headers with opcode 0x00, 0x01, 0x03-0x1F or 0xE8-0xFF are consumed as single words, with no output and no stall.
- R10: An open packet waits for words indefinitely. Low `out_ready` during a packet holds `in_ready` low. Words inside a packet are forwarded, even when their top byte looks like a settings opcode, and they leave the settings bank untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Packet word valid |
| out_ready | input | 1 | Downstream accepts the packet word |
| out_data | output | 32 | Packet word |
| out_first | output | 1 | Word is a packet header |
| out_last | output | 1 | Word ends the packet |
| out_kind | output | 2 | 0 draw, 1 copy, 2 image write, 3 image read |
| set_bank | output | 256 | Settings entries, entry i at bits 32*i+31:32*i |

## Verification
On every cycle the embedded assertions check the following:
- the first flag agrees with an independent model of whether a packet is open;
- the kind holds steady inside a packet;
- copy and image packets close after exactly their word counts;
- settings writes land in the indexed entry;
- no output appears without input;
- body words never disturb the bank.

The exact parameter count of each drawing opcode, the terminator positions for both polyline strides, the dropping of no-op opcodes, and recovery from a reset in mid-packet can only be shown by the bench's vector walk and directed scenarios.

// File: rtl/gpu_packet_framer.sv
module gpu_packet_framer #(
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data,
  output logic            out_first,
  output logic            out_last,
  output logic [1:0]      out_kind,
  output logic [8*DW-1:0] set_bank
);
  localparam int NSET = 8;
  localparam int PC_W = 4;
  localparam logic [DW-1:0] TERM_MASK = DW'(32'hF000F000);
  localparam logic [DW-1:0] TERM_VAL  = DW'(32'h50005000);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [1:0] {M_FIXED, M_FLAT, M_SHADED} mode_t;

  function automatic logic [PC_W-1:0] param_count(input logic [7:0] op);
    logic [PC_W-1:0] pc;
    pc = '0;
    if (op == 8'h02) pc = 4'd2;
    else if (op[7:5] == 3'b001) begin
      case (op[4:2])
        3'd0: pc = 4'd3;  3'd1: pc = 4'd6;  3'd2: pc = 4'd4;  3'd3: pc = 4'd8;
        3'd4: pc = 4'd5;  3'd5: pc = 4'd8;  3'd6: pc = 4'd7;  default: pc = 4'd11;
      endcase
    end else if (op[7:6] == 2'b01) begin
      case (op[5:2])
        4'd0, 4'd1, 4'd8, 4'd13, 4'd15: pc = 4'd2;
        4'd2, 4'd3, 4'd4, 4'd5, 4'd9:   pc = 4'd3;
        4'd6, 4'd7:                     pc = 4'd4;
        4'd11:                          pc = 4'd0;
        default:                        pc = 4'd1;
      endcase
    end else if (op[7:5] == 3'b100) pc = 4'd3;
    else if (op[7:5] == 3'b101 || op[7:5] == 3'b110) pc = 4'd2;
    return pc;
  endfunction

  logic [7:0]       op;
  logic             hdr_set, hdr_pkt, hdr_last, body_last, term, acc;
  logic [1:0]       hdr_kind;
  mode_t            hdr_mode;
  logic [PC_W-1:0]  hdr_pc;

  logic             busy, odd;
  logic [IDX_W-1:0] idx;
  logic [PC_W-1:0]  pc_q;
  mode_t            mode_q;
  logic [1:0]       kind_q;
  logic [DW-1:0]    bank [NSET];

  assign op       = in_data[DW-1 -: 8];
  assign hdr_set  = op[7:3] == 5'b11100;
  assign hdr_pkt  = op == 8'h02 || (op >= 8'h20 && op <= 8'hDF);
  assign hdr_pc   = param_count(op);
  assign hdr_kind = op[7] ? (op[6:5] + 2'd1) : 2'd0;
  assign hdr_mode = (op[7:3] == 5'b01001) ? M_FLAT :
                    (op[7:3] == 5'b01011) ? M_SHADED : M_FIXED;
  assign hdr_last = hdr_mode == M_FIXED && hdr_pc == '0;

  assign term = (in_data & TERM_MASK) == TERM_VAL;
  always_comb begin
    case (mode_q)
      M_FLAT:   body_last = term && idx >= IDX_W'(3);
      M_SHADED: body_last = term && idx >= IDX_W'(4) && !odd;
      default:  body_last = idx == IDX_W'(pc_q);
    endcase
  end

  assign out_valid = in_valid && (busy || hdr_pkt);
  assign in_ready  = (busy || hdr_pkt) ? out_ready : 1'b1;
  assign out_data  = in_data;
  assign out_first = !busy;
  assign out_last  = busy ? body_last : hdr_last;
  assign out_kind  = busy ? kind_q : hdr_kind;
  assign acc       = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      odd    <= 1'b0;
      idx    <= '0;
      pc_q   <= '0;
      mode_q <= M_FIXED;
      kind_q <= 2'd0;
    end else if (acc) begin
      if (!busy) begin
        if (hdr_pkt && !hdr_last) begin
          busy   <= 1'b1;
          idx    <= IDX_W'(1);
          odd    <= 1'b1;
          pc_q   <= hdr_pc;
          mode_q <= hdr_mode;
          kind_q <= hdr_kind;
        end
      end else if (body_last) begin
        busy <= 1'b0;
      end else begin
        if (idx != IDX_MAX) idx <= idx + IDX_W'(1);
        odd <= !odd;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSET; i++) begin
      if (!rst_n)
        bank[i] <= {8'(8'hE0 + i), {(DW-8){1'b0}}};
      else if (acc && !busy && hdr_set && op[2:0] == 3'(i))
        bank[i] <= in_data;
    end
  end

  for (genvar g = 0; g < NSET; g++) begin : g_bank
    assign set_bank[g*DW +: DW] = bank[g];
  end

  logic       chk_open;
  logic [1:0] chk_kind;
  logic [7:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_open <= 1'b0;
      chk_kind <= 2'd0;
      chk_cnt  <= '0;
    end else if (out_valid && out_ready) begin
      if (out_last) begin
        chk_open <= 1'b0;
        chk_cnt  <= '0;
      end else begin
        chk_open <= 1'b1;
        if (chk_cnt != 8'hFF) chk_cnt <= chk_cnt + 8'd1;
      end
      if (out_first) chk_kind <= out_kind;
    end
  end

  // R2
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == !chk_open));
  // R2
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_first |-> out_kind == chk_kind);
  // R7
  copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && out_kind == 2'd1 |-> chk_cnt == 8'd3);
  // R7
  image_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && out_kind[1] |-> chk_cnt == 8'd2);
  // R8
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !chk_open && in_data[DW-1 -: 5] == 5'b11100
    |=> set_bank[$past(in_data[DW-6 -: 3]) * DW +: DW] == $past(in_data));
  // R10
  no_invent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
  // R10
  body_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && chk_open |=> $stable(set_bank));
endmodule

// File: tb/gpu_packet_framer_test.sv
module gpu_packet_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_first, out_last;
  logic [31:0] out_data;
  logic [1:0] out_kind;
  logic [255:0] set_bank;
  int total = 0, fails = 0, cyc = 0;

  always #4 clk = !clk;

  gpu_packet_framer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .out_kind(out_kind), .set_bank(set_bank)
  );

  // {opcode, param count, kind, req: 0=R3 1=R4 2=R7}
  localparam int NV = 27;
  localparam logic [15:0] VEC [NV] = '{
    {8'h02, 4'd2, 2'd0, 2'd1},
    {8'h20, 4'd3, 2'd0, 2'd0}, {8'h24, 4'd6, 2'd0, 2'd0}, {8'h28, 4'd4, 2'd0, 2'd0},
    {8'h2C, 4'd8, 2'd0, 2'd0}, {8'h30, 4'd5, 2'd0, 2'd0}, {8'h34, 4'd8, 2'd0, 2'd0},
    {8'h38, 4'd7, 2'd0, 2'd0}, {8'h3F, 4'd11, 2'd0, 2'd0},
    {8'h40, 4'd2, 2'd0, 2'd1}, {8'h47, 4'd2, 2'd0, 2'd1}, {8'h50, 4'd3, 2'd0, 2'd1},
    {8'h54, 4'd3, 2'd0, 2'd1}, {8'h60, 4'd2, 2'd0, 2'd1}, {8'h64, 4'd3, 2'd0, 2'd1},
    {8'h68, 4'd1, 2'd0, 2'd1}, {8'h6C, 4'd0, 2'd0, 2'd1}, {8'h70, 4'd1, 2'd0, 2'd1},
    {8'h74, 4'd2, 2'd0, 2'd1}, {8'h78, 4'd1, 2'd0, 2'd1}, {8'h7C, 4'd2, 2'd0, 2'd1},
    {8'h80, 4'd3, 2'd1, 2'd2}, {8'h9F, 4'd3, 2'd1, 2'd2}, {8'hA0, 4'd2, 2'd2, 2'd2},
    {8'hBF, 4'd2, 2'd2, 2'd2}, {8'hC0, 4'd2, 2'd3, 2'd2}, {8'hDF, 4'd2, 2'd3, 2'd2}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input bit ev, input bit ef, input bit el,
                      input logic [1:0] ek, input string tag);
    logic [63:0] act, exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    act = {24'h0, out_valid, out_first, out_last, out_kind, in_ready, out_data};
    exp = {24'h0, ev, ef, el, ek, 1'b1, w};
    if (ev) check(out_valid && out_first == ef && out_last == el && out_kind == ek &&
                  in_ready && out_data == w, tag, act, exp);
    else check(!out_valid && in_ready, tag, {62'h0, out_valid, in_ready}, 64'h1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic bank_chk(input int i, input logic [31:0] exp, input string tag);
    check(set_bank[i*32 +: 32] == exp, tag, {32'h0, set_bank[i*32 +: 32]}, {32'h0, exp});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; fails++;
      $display("FAIL watchdog expired (R10 run hung) actual=%0d expected<=50000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check(!out_valid && in_ready, "R1 idle after reset", {62'h0, out_valid, in_ready}, 64'h1);
    for (int i = 0; i < 8; i++) bank_chk(i, {8'(8'hE0 + i), 24'h0}, "R1 bank reset");

    // R3 R4 R7 vector walk; body words carry a settings-like top byte (R10)
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (VEC[v][1:0] == 2'd0) ? "R3 param count" :
            (VEC[v][1:0] == 2'd1) ? "R4 param count" : "R7 class/count";
      for (int k = 0; k <= int'(VEC[v][7:4]); k++)
        xfer(k == 0 ? {VEC[v][15:8], 24'h123456} : {8'hE1, 24'(k)}, 1'b1, k == 0,
             k == int'(VEC[v][7:4]), VEC[v][3:2], tag);
    end
    bank_chk(1, 32'hE100_0000, "R10 body words leave bank");

    // R8 settings capture
    xfer(32'hE30A_BCDE, 1'b0, 1'b0, 1'b0, 2'd0, "R8 setting not forwarded");
    bank_chk(3, 32'hE30A_BCDE, "R8 setting stored");
    bank_chk(4, 32'hE400_0000, "R8 neighbour untouched");
    xfer(32'hE7FF_FFFF, 1'b0, 1'b0, 1'b0, 2'd0, "R8 setting not forwarded");
    bank_chk(7, 32'hE7FF_FFFF, "R8 top entry stored");

    // R9 no-ops
    xfer(32'h0000_0001, 1'b0, 1'b0, 1'b0, 2'd0, "R9 nop 00");
    xfer(32'h0150_0050, 1'b0, 1'b0, 1'b0, 2'd0, "R9 nop 01");
    xfer(32'h1F00_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R9 nop 1F");
    xfer(32'hE8AA_AAAA, 1'b0, 1'b0, 1'b0, 2'd0, "R9 nop E8");
    xfer(32'hFF00_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R9 nop FF");
    bank_chk(0, 32'hE000_0000, "R9 E8 leaves entry 0");

    // R5 flat polyline: terminator shapes at index 1,2 ignored, closes at index 4
    xfer(32'h4800_0000, 1'b1, 1'b1, 1'b0, 2'd0, "R5 flat header");
    xfer(32'h5000_5000, 1'b1, 1'b0, 1'b0, 2'd0, "R5 idx1 not tested");
    xfer(32'h5000_5000, 1'b1, 1'b0, 1'b0, 2'd0, "R5 idx2 not tested");
    xfer(32'h1234_5678, 1'b1, 1'b0, 1'b0, 2'd0, "R5 idx3 plain");
    xfer(32'h5A00_5FFF, 1'b1, 1'b0, 1'b1, 2'd0, "R5 masked terminator");
    // R5 shortest flat polyline
    xfer(32'h4C00_0000, 1'b1, 1'b1, 1'b0, 2'd0, "R5 flat header");
    xfer(32'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R5 body");
    xfer(32'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R5 body");
    xfer(32'h5555_5555, 1'b1, 1'b0, 1'b1, 2'd0, "R5 terminator at idx3");

    // R6 shaded polyline: only even indices from 4
    xfer(32'h5800_0000, 1'b1, 1'b1, 1'b0, 2'd0, "R6 shaded header");
    xfer(32'h5000_5000, 1'b1, 1'b0, 1'b0, 2'd0, "R6 idx1");
    xfer(32'h5000_5000, 1'b1, 1'b0, 1'b0, 2'd0, "R6 idx2");
    xfer(32'h5000_5000, 1'b1, 1'b0, 1'b0, 2'd0, "R6 idx3");
    xfer(32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'd0, "R6 idx4 plain");
    xfer(32'h5000_5000, 1'b1, 1'b0, 1'b0, 2'd0, "R6 odd idx5 ignored");
    xfer(32'h5FFF_5000, 1'b1, 1'b0, 1'b1, 2'd0, "R6 idx6 closes");

    // R10 incomplete packet waits, backpressure, body not decoded
    xfer(32'h8000_0000, 1'b1, 1'b1, 1'b0, 2'd1, "R10 copy header");
    xfer(32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd1, "R10 copy p1");
    repeat (4) @(negedge clk);
    #1 check(!out_valid, "R10 idle while open", {63'h0, out_valid}, 64'h0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'hE512_3456;
    #1 check(out_valid && !in_ready, "R10 backpressure", {62'h0, out_valid, in_ready}, 64'h2);
    @(posedge clk);
    #1 out_ready = 1'b1; in_valid = 1'b0;
    xfer(32'hE512_3456, 1'b1, 1'b0, 1'b0, 2'd1, "R10 E5-shaped body forwarded");
    bank_chk(5, 32'hE500_0000, "R10 body kept out of bank");
    xfer(32'h0000_0003, 1'b1, 1'b0, 1'b1, 2'd1, "R10 copy completes");

    // R1 reset mid-packet
    xfer(32'hA000_0000, 1'b1, 1'b1, 1'b0, 2'd2, "R1 write header");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    bank_chk(3, 32'hE300_0000, "R1 bank back to reset");
    xfer(32'h0200_0000, 1'b1, 1'b1, 1'b0, 2'd0, "R1 header after reset");
    xfer(32'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R4 fill p1");
    xfer(32'h0, 1'b1, 1'b0, 1'b1, 2'd0, "R2 fill last");

    summary();
    $finish;
  end
endmodule